// File: doc/BRIEF.md
# Eight-bit Compare and PWM Timer

This block is an eight-bit up-counter that runs on every clock while enabled. A compare register and a single timer output pin go with it. Software drives it through a byte-wide write port. Each write carries a per-bit mask, so the port can update a whole byte or any single bit. A select line chooses between the mode control byte and the compare byte. The read port returns the selected register at once.

The control byte has two modes. In restart mode the counter returns to zero on the clock after it equals the compare value, so the period is compare plus one cycles. Each match can optionally invert the output flip-flop. In PWM mode the counter runs freely from 00H to FFH and wraps. The flip-flop goes active at the wrap and inactive after the match. A polarity bit selects active-high or active-low, and a compare value written mid-period only takes effect at the next wrap. In both modes, software can force the flip-flop high or low with a two-bit command carried in the same control byte. An enable bit gates the pin. Every match raises a one-cycle interrupt pulse.

Top module: `tmr8_timer`

## Requirements
- R1: After reset the control byte reads 00H, the compare byte reads 00H, the count is 0, the pin is low and the interrupt is low, and the count stays 0.
- R2: Control bit 7 is the run bit. Writing it to 0 makes the count 0 after that write and holds it there with no interrupt. Writing it to 1 shows count 0 after the write, and the count then increments by one per clock.
- R3: With control bit 6 at 0 (restart mode) and the run bit set, a count equal to the compare value is followed by count 0 on the next clock, so the count sequence repeats every compare+1 cycles and never exceeds the compare value.
- R4: Control bits 3:2 are a flip-flop command taking effect at the write: 10 sets it, 01 clears it, 00 and 11 leave it unchanged. Bits 5:2 always read back 0.
- R5: In restart mode with control bit 1 at 1, the flip-flop inverts on every match, so the pin changes exactly in the cycles where the interrupt is high. With bit 1 at 0, matches leave the pin unchanged.
- R6: With control bit 0 at 0 the pin is low whatever the flip-flop holds. With it at 1 the pin shows the flip-flop, which keeps its value while the pin is gated.
- R7: With bit 6 at 1 (PWM mode) the count wraps FFH to 00H and the flip-flop is active while the count is at most the compare value. Bit 1 at 0 makes the active pin level high, and at 1 makes it low. A compare value of FFH keeps the output active for the whole period.
- R8: In PWM mode a compare write reads back at once but only changes the output from the next wrap.
- R9: The interrupt pulses high for one cycle after each match, in both modes. In restart mode it coincides with count 0.
- R10: A set or clear command written in the same cycle as a match-driven toggle wins over the toggle.
- R11: Only bits whose mask bit is 1 change on a write, for both the control byte and the compare byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_sel | input | 1 | Register select: 0 control byte, 1 compare byte |
| bus_wdata | input | CW | Write data |
| bus_wmask | input | CW | Per-bit write mask |
| bus_rdata | output | CW | Readback of the selected register |
| count_o | output | CW | Current counter value |
| tmr_out | output | 1 | Timer output pin |
| match_irq | output | 1 | One-cycle match interrupt pulse |

## Verification
A wrong counter state shows on count_o within one clock. It breaks the compare+1 spacing of the interrupt pulses within one period in restart mode, and within 256 cycles in PWM mode. A corrupted flip-flop is visible on the pin as soon as the output enable is 1. The bench checks the pin against the count on every cycle of a PWM period and checks pin changes against interrupt cycles in toggle mode. A stale compare copy shows up only across a wrap, so that case is probed on both sides of the wrap after a mid-period write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  localparam int B_RUN  = 7;
  localparam int B_PWM  = 6;
  localparam int B_CMDH = 3;
  localparam int B_CMDL = 2;
  localparam int B_INV  = 1;
  localparam int B_OE   = 0;

  // bits that actually hold state; 5:2 are fixed or write-only
  localparam logic [7:0] CTRL_KEEP = 8'hC3;

  typedef enum logic [1:0] {
    FFC_NONE = 2'b00,
    FFC_CLR  = 2'b01,
    FFC_SET  = 2'b10,
    FFC_BAD  = 2'b11
  } ffcmd_e;

  function automatic logic [7:0] merge_ctrl(input logic [7:0] old_v,
                                            input logic [7:0] new_v,
                                            input logic [7:0] msk);
    return ((old_v & ~msk) | (new_v & msk)) & CTRL_KEEP;
  endfunction

  function automatic ffcmd_e decode_cmd(input logic [1:0] d, input logic [1:0] m);
    logic [1:0] eff;
    eff = d & m;
    return ffcmd_e'(eff);
  endfunction

  function automatic logic pin_level(input logic ff, input logic pwm,
                                     input logic lvl, input logic oe);
    return oe & (ff ^ (pwm & lvl));
  endfunction

endpackage

// File: rtl/tmr8_ctrl_reg.sv
module tmr8_ctrl_reg
  import tmr8_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [CW-1:0] wr_data,
  input  logic [CW-1:0] wr_mask,
  output logic          run,
  output logic          run_nxt,
  output logic          pwm,
  output logic          inv_lvl,
  output logic          oe,
  output logic [CW-1:0] cmp_buf,
  output logic          cmd_set,
  output logic          cmd_clr,
  output logic [CW-1:0] rd_data
);

  logic [7:0] ctrl_q;
  logic [7:0] ctrl_d;
  logic       ctrl_wr;
  logic       cmp_wr;
  ffcmd_e     cmd;

  always_comb begin
    ctrl_wr = wr_en & ~wr_sel;
    cmp_wr  = wr_en & wr_sel;
    ctrl_d  = ctrl_wr ? merge_ctrl(ctrl_q, wr_data[7:0], wr_mask[7:0]) : ctrl_q;
    cmd     = ctrl_wr ? decode_cmd(wr_data[B_CMDH:B_CMDL], wr_mask[B_CMDH:B_CMDL])
                      : FFC_NONE;
    cmd_set = (cmd == FFC_SET);
    cmd_clr = (cmd == FFC_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 8'h00;
      cmp_buf <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (cmp_wr) cmp_buf <= (cmp_buf & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  assign run     = ctrl_q[B_RUN];
  assign run_nxt = ctrl_d[B_RUN];
  assign pwm     = ctrl_q[B_PWM];
  assign inv_lvl = ctrl_q[B_INV];
  assign oe      = ctrl_q[B_OE];
  assign rd_data = wr_sel ? cmp_buf : CW'(ctrl_q);

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          run_nxt,
  input  logic          pwm,
  input  logic [CW-1:0] cmp_buf,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cmp_act,
  output logic          match_hit,
  output logic          wrap_hit
);

  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c,
                                         input logic [CW-1:0] cmp,
                                         input logic free_run);
    if (!free_run && c == cmp) return '0;
    return c + 1'b1;
  endfunction

  assign match_hit = run & (count == cmp_act);
  assign wrap_hit  = run & pwm & (count == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      cmp_act <= '0;
    end else begin
      if (!run_nxt || !run) count <= '0;
      else                  count <= step(count, cmp_act, pwm);
      if (!run || !pwm || wrap_hit) cmp_act <= cmp_buf;
    end
  end

endmodule

// File: rtl/tmr8_out_ff.sv
module tmr8_out_ff
  import tmr8_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_set,
  input  logic cmd_clr,
  input  logic pwm,
  input  logic inv_lvl,
  input  logic oe,
  input  logic match_hit,
  input  logic wrap_hit,
  output logic ff,
  output logic pin
);

  logic ff_d;

  always_comb begin
    ff_d = ff;
    if (cmd_set)                     ff_d = 1'b1;
    else if (cmd_clr)                ff_d = 1'b0;
    else if (pwm && wrap_hit)        ff_d = 1'b1;
    else if (pwm && match_hit)       ff_d = 1'b0;
    else if (!pwm && inv_lvl && match_hit) ff_d = ~ff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= 1'b0;
    else        ff <= ff_d;
  end

  assign pin = pin_level(ff, pwm, inv_lvl, oe);

endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_sel,
  input  logic [CW-1:0] bus_wdata,
  input  logic [CW-1:0] bus_wmask,
  output logic [CW-1:0] bus_rdata,
  output logic [CW-1:0] count_o,
  output logic          tmr_out,
  output logic          match_irq
);

  logic          run, run_nxt, pwm, inv_lvl, oe;
  logic          cmd_set, cmd_clr;
  logic [CW-1:0] cmp_buf, cmp_act;
  logic          match_hit, wrap_hit;
  logic          ff;
  logic          irq_q;

  tmr8_ctrl_reg #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(bus_we), .wr_sel(bus_sel), .wr_data(bus_wdata), .wr_mask(bus_wmask),
    .run(run), .run_nxt(run_nxt), .pwm(pwm), .inv_lvl(inv_lvl), .oe(oe),
    .cmp_buf(cmp_buf), .cmd_set(cmd_set), .cmd_clr(cmd_clr), .rd_data(bus_rdata)
  );

  tmr8_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .run(run), .run_nxt(run_nxt), .pwm(pwm), .cmp_buf(cmp_buf),
    .count(count_o), .cmp_act(cmp_act), .match_hit(match_hit), .wrap_hit(wrap_hit)
  );

  tmr8_out_ff u_off (
    .clk(clk), .rst_n(rst_n),
    .cmd_set(cmd_set), .cmd_clr(cmd_clr), .pwm(pwm), .inv_lvl(inv_lvl), .oe(oe),
    .match_hit(match_hit), .wrap_hit(wrap_hit), .ff(ff), .pin(tmr_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= match_hit;
  end

  assign match_irq = irq_q;

endmodule

// File: rtl/tmr8_timer_sva.sv
module tmr8_timer_sva #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          pwm,
  input logic          oe,
  input logic          bus_sel,
  input logic [CW-1:0] bus_rdata,
  input logic [CW-1:0] count_o,
  input logic [CW-1:0] cmp_act,
  input logic          cmd_set,
  input logic          cmd_clr,
  input logic          ff,
  input logic          tmr_out,
  input logic          match_irq
);

  assert_stop_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (count_o == '0));

  assert_match_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pwm && count_o == cmp_act) |=> (count_o == '0));

  assert_cmd_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata[5:2] == 4'b0000));

  assert_pin_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !tmr_out);

  assert_pwm_wrap_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pwm && count_o == {CW{1'b1}} && !cmd_clr) |=> ff);

  assert_irq_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_irq && $past(!pwm)) |-> (count_o == '0));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> ff);

  assert_clr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> !ff);

endmodule

bind tmr8_timer tmr8_timer_sva #(.CW(CW)) u_sva (
  .clk(clk), .rst_n(rst_n), .run(run), .pwm(pwm), .oe(oe),
  .bus_sel(bus_sel), .bus_rdata(bus_rdata), .count_o(count_o), .cmp_act(cmp_act),
  .cmd_set(cmd_set), .cmd_clr(cmd_clr), .ff(ff), .tmr_out(tmr_out),
  .match_irq(match_irq)
);

// File: tb/tmr8_timer_tb.sv
`timescale 1ns/1ps
module tmr8_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic       sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] wmask = 8'h00;
  logic [7:0] rdata, count;
  logic       pin, irq;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tmr8_timer #(.CW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_sel(sel),
    .bus_wdata(wdata), .bus_wmask(wmask), .bus_rdata(rdata),
    .count_o(count), .tmr_out(pin), .match_irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // caller stands at a negedge; write is taken at the following posedge
  task automatic wr(input logic s, input logic [7:0] d, input logic [7:0] m);
    we = 1'b1; sel = s; wdata = d; wmask = m;
    @(negedge clk);
    we = 1'b0; wmask = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_count(input logic [7:0] v);
    for (int i = 0; i < 600; i++) begin
      if (count == v) return;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    sel = 1'b0; #0;
    chk(rdata == 8'h00, "R1 ctrl after reset", rdata, 0);
    sel = 1'b1; #1;
    chk(rdata == 8'h00, "R1 compare after reset", rdata, 0);
    sel = 1'b0;
    chk(pin == 1'b0 && irq == 1'b0, "R1 pin/irq after reset", {pin, irq}, 0);
    idle(5);
    chk(count == 8'h00, "R1 count held at 0", count, 0);
  endtask

  task automatic t_readback();
    wr(1'b0, 8'hFF, 8'hFF);
    sel = 1'b0; #1;
    chk(rdata == 8'hC3, "R4 ctrl readback zeros 5:2", rdata, 8'hC3);
    wr(1'b0, 8'h00, 8'h01);
    sel = 1'b0; #1;
    chk(rdata == 8'hC2, "R11 single bit write", rdata, 8'hC2);
    wr(1'b0, 8'h00, 8'hFF);
    wr(1'b1, 8'h5A, 8'hFF);
    wr(1'b1, 8'h00, 8'hF0);
    sel = 1'b1; #1;
    chk(rdata == 8'h0A, "R11 masked compare write", rdata, 8'h0A);
    sel = 1'b0;
  endtask

  task automatic t_swcmd();
    wr(1'b0, 8'h01, 8'hFF);
    chk(pin == 1'b0, "R6 enabled pin, ff clear", pin, 0);
    wr(1'b0, 8'h08, 8'h0C);
    chk(pin == 1'b1, "R4 set command", pin, 1);
    sel = 1'b0; #1;
    chk(rdata == 8'h01, "R4 command bits read 0", rdata, 1);
    wr(1'b0, 8'h0C, 8'h0C);
    chk(pin == 1'b1, "R4 code 11 ignored (high)", pin, 1);
    wr(1'b0, 8'h04, 8'h0C);
    chk(pin == 1'b0, "R4 clear command", pin, 0);
    wr(1'b0, 8'h0C, 8'h0C);
    chk(pin == 1'b0, "R4 code 11 ignored (low)", pin, 0);
    wr(1'b0, 8'h08, 8'h0D);
    chk(pin == 1'b0, "R6 gated pin low while ff set", pin, 0);
    wr(1'b0, 8'h01, 8'h01);
    chk(pin == 1'b1, "R6 ff kept while gated", pin, 1);
    wr(1'b0, 8'h04, 8'h0C);
  endtask

  task automatic t_match_period();
    int last, gaps_bad, zeros_bad, npulse, overmax, pin_moves;
    logic p0;
    last = -1; gaps_bad = 0; zeros_bad = 0; npulse = 0; overmax = 0; pin_moves = 0;
    wr(1'b1, 8'h05, 8'hFF);
    wr(1'b0, 8'h81, 8'hFF);
    chk(count == 8'h00, "R2 count 0 right after start", count, 0);
    @(negedge clk);
    chk(count == 8'h01, "R2 count increments", count, 1);
    p0 = pin;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (count > 8'h05) overmax++;
      if (pin != p0) pin_moves++;
      if (irq) begin
        npulse++;
        if (count != 8'h00) zeros_bad++;
        if (last >= 0 && i - last != 6) gaps_bad++;
        last = i;
      end
    end
    chk(overmax == 0, "R3 count never above compare", overmax, 0);
    chk(npulse >= 6 && gaps_bad == 0, "R3 period compare+1", gaps_bad, 0);
    chk(zeros_bad == 0, "R9 irq with count 0", zeros_bad, 0);
    chk(pin_moves == 0, "R5 no toggle when disabled", pin_moves, 0);
  endtask

  task automatic t_toggle();
    int bad, flips;
    logic prev;
    bad = 0; flips = 0;
    wr(1'b0, 8'h02, 8'h02);
    prev = pin;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if ((pin != prev) != irq) bad++;
      if (pin != prev) flips++;
      prev = pin;
    end
    chk(bad == 0 && flips >= 6, "R5 pin toggles exactly on match", bad, 0);
  endtask

  task automatic t_priority();
    int guard;
    guard = 0;
    @(negedge clk);
    while (!(count == 8'h05 && pin == 1'b1) && guard < 100) begin
      @(negedge clk); guard++;
    end
    wr(1'b0, 8'h08, 8'h0C);
    chk(irq == 1'b1 && pin == 1'b1, "R10 set beats toggle", {irq, pin}, 3);
    guard = 0;
    while (!(count == 8'h05 && pin == 1'b0) && guard < 100) begin
      @(negedge clk); guard++;
    end
    wr(1'b0, 8'h04, 8'h0C);
    chk(irq == 1'b1 && pin == 1'b0, "R10 clear beats toggle", {irq, pin}, 2);
  endtask

  task automatic t_stop();
    int bad;
    bad = 0;
    wr(1'b0, 8'h00, 8'h80);
    chk(count == 8'h00, "R2 count 0 right after stop", count, 0);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      if (count != 8'h00 || irq) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R2 stopped: count 0, no irq", bad, 0);
    wr(1'b0, 8'h00, 8'hFF);
  endtask

  task automatic pwm_window(input logic [7:0] cmpv, input logic lvl, input string tag);
    int bad, high;
    logic expv;
    bad = 0; high = 0;
    wait_count(8'h00);
    for (int i = 0; i < 256; i++) begin
      expv = (count <= cmpv) ^ lvl;
      if (pin != expv) bad++;
      if (pin) high++;
      @(negedge clk);
    end
    chk(bad == 0, tag, high, (lvl ? 255 - int'(cmpv) : int'(cmpv) + 1));
  endtask

  task automatic t_pwm();
    wr(1'b1, 8'd63, 8'hFF);
    wr(1'b0, 8'hC1, 8'hFF);
    idle(260);
    pwm_window(8'd63, 1'b0, "R7 pwm duty active-high");
    wr(1'b0, 8'h02, 8'h02);
    pwm_window(8'd63, 1'b1, "R7 pwm duty active-low");
    wr(1'b1, 8'hFF, 8'hFF);
    idle(260);
    pwm_window(8'hFF, 1'b1, "R7 compare FFH active-low always");
    wr(1'b0, 8'h00, 8'h02);
    pwm_window(8'hFF, 1'b0, "R7 compare FFH active-high always");
  endtask

  task automatic t_pwm_buffer();
    wr(1'b1, 8'd200, 8'hFF);
    idle(300);
    wait_count(8'd10);
    wr(1'b1, 8'd20, 8'hFF);
    sel = 1'b1; #1;
    chk(rdata == 8'd20, "R8 compare readback immediate", rdata, 20);
    sel = 1'b0;
    wait_count(8'd50);
    chk(pin == 1'b1, "R8 old compare until wrap", pin, 1);
    wait_count(8'd0);
    wait_count(8'd21);
    chk(irq == 1'b1, "R9 irq after pwm match", irq, 1);
    wait_count(8'd50);
    chk(pin == 1'b0, "R8 new compare after wrap", pin, 0);
  endtask

  initial begin
    #(100000 * 4);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_swcmd();
    t_match_period();
    t_toggle();
    t_priority();
    t_stop();
    t_pwm();
    t_pwm_buffer();
    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule